// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request source and an external asynchronous static RAM. The RAM has two byte lanes and a separate semaphore space. Each accepted request becomes one complete bus cycle on the memory pins: an active-low RAM enable, semaphore enable, read/write line, output enable, upper and lower byte strobes, an address bus and a 16-bit tri-state data bus. Every interval is a whole number of clock cycles set by a parameter, so the timing can be fitted to the memory and clock in use.

Writes follow one of two orderings, chosen when the block is built. In read/write-led mode (`WMODE=0`), the enable and the byte strobes fall first and the read/write line forms the write pulse. In enable-led mode (`WMODE=1`), the read/write line falls first and the enable forms the pulse, so the memory never turns its outputs on. In read/write-led mode the output enable may be left low through the write (`OE_LOW_WR=1`). In that case the pulse is lengthened so that the memory can release the bus before the block drives data onto it. A read holds the memory selected for a set access time, captures the enabled lanes and returns them with a one-cycle response strobe. It then leaves the bus idle for a turnaround gap.

The state machine has six states: `ST_IDLE`, `ST_SETUP`, `ST_PULSE`, `ST_HOLD`, `ST_READ` and `ST_TURN`. Its transitions are:
- accept-write: `ST_IDLE` to `ST_SETUP`
- accept-read: `ST_IDLE` to `ST_READ`
- setup-done: `ST_SETUP` to `ST_PULSE`
- pulse-done: `ST_PULSE` to `ST_HOLD`
- hold-done: `ST_HOLD` to `ST_IDLE`
- access-done: `ST_READ` to `ST_TURN`
- turn-done: `ST_TURN` to `ST_IDLE`

Each state other than idle lasts exactly the number of cycles set for it.

Top module: `sram_seq`

## Requirements
- R1: `req_ready` is high only in `ST_IDLE`. It drops in the cycle after a request is accepted, and one request is taken per access. While ready is high, every memory control pin is high and the data bus is not driven.
- R2: The address bus changes only when a request is accepted. It never changes between two cycles in which both the read/write line and the active enable are low.
- R3: With `req_sem=0` the access drives `mem_ce_n` low and keeps `mem_sem_n` high. With `req_sem=1` it is the reverse. The two enables are never low together, and the two spaces keep separate contents.
- R4: `req_be[1]` gates `mem_ub_n` (data bits 15:8) and `req_be[0]` gates `mem_lb_n` (bits 7:0). A lane whose bit is 0 is neither written nor read: its memory byte keeps its value, and its read result is 0.
- R5: In read/write-led mode, the enable and strobes are low for `T_SETUP` cycles before the read/write line falls. The read/write line then stays low for max(`T_PULSE`,`T_DSETUP`) cycles, or for max(`T_PULSE`, `T_TURNOFF`+`T_DSETUP`) cycles when the output enable is held low during writes.
- R6: The block never drives the data bus while the memory may be driving it (enable low, read/write high, output enable low). When the output enable is held low during a write, the block starts driving `T_TURNOFF` cycles after the read/write line falls.
- R7: After the write pulse ends, the data stays driven and the address stays unchanged for `T_HOLD` cycles. The next access then starts with every control pin high.
- R8: In enable-led mode, the read/write line is low for `T_SETUP` cycles before the enable falls. The enable then stays low for max(`T_PULSE`,`T_DSETUP`) cycles, and rises `T_HOLD` cycles before the read/write line. The output enable stays high for the whole write.
- R9: A read holds the enable, the strobes and the output enable low, with read/write high, for `T_ACCESS` cycles. `rsp_valid` is then high for exactly one cycle with the captured data, and ready returns `T_TURNOFF` cycles after that.
- R10: Data written to an address and space is returned by a later read of the same address and space, lane by lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sem | input | 1 | 1 = semaphore space, 0 = RAM space |
| req_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | AW | Memory address bus |
| mem_ce_n | output | 1 | RAM space enable, active low |
| mem_sem_n | output | 1 | Semaphore space enable, active low |
| mem_rw_n | output | 1 | High = read, low = write |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
Two instances are exercised: one in read/write-led mode with the output enable held low, and one in enable-led mode. This separates the stretched pulse from the plain pulse and the two strobe orderings. A bench-side memory model measures, for every access, how many cycles the bus spends before, inside and after the write window. These counts tell apart setup, pulse-width and hold errors as well as read access and turnaround errors. Random mixes of space, lane mask, address and data are checked against a bench scoreboard on read-back. Directed cases cover an all-lanes-off write, single-lane writes, and the same address in both spaces, which exposes lane gating and space steering faults.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    localparam int DW = 16;
    localparam int LANES = DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_READ,
        ST_TURN
    } seq_state_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
// Interval counter: a load of N makes expired rise after N cycles in the state.
module sram_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] remain,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign remain  = cnt_q;
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_strobes.sv
// Space steering and per-lane strobe gating.
module sram_seq_strobes
    import sram_seq_pkg::*;
(
    input  logic             en_on,
    input  logic             lanes_on,
    input  logic             sel_sem,
    input  logic [LANES-1:0] be,
    output logic             ce_n,
    output logic             sem_n,
    output logic [LANES-1:0] lane_n
);
    assign ce_n  = ~(en_on & ~sel_sem);
    assign sem_n = ~(en_on & sel_sem);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = ~(lanes_on & be[g]);
    end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int AW        = 12,
    parameter int T_SETUP   = 1,
    parameter int T_PULSE   = 2,
    parameter int T_DSETUP  = 2,
    parameter int T_TURNOFF = 2,
    parameter int T_HOLD    = 1,
    parameter int T_ACCESS  = 3,
    parameter int WMODE     = 0,
    parameter int OE_LOW_WR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_sem,
    input  logic [1:0]    req_be,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic          rsp_valid,
    output logic [15:0]   rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_sem_n,
    output logic          mem_rw_n,
    output logic          mem_oe_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    inout  wire  [15:0]   mem_dq
);
    localparam bit OE_HELD      = (WMODE == 0) && (OE_LOW_WR != 0);
    localparam int PULSE_PLAIN  = int'(umax(T_PULSE, T_DSETUP));
    localparam int PULSE_STRETCH = int'(umax(T_PULSE, T_TURNOFF + T_DSETUP));
    localparam int PULSE_EFF    = OE_HELD ? PULSE_STRETCH : PULSE_PLAIN;
    localparam int DRV_DELAY    = OE_HELD ? T_TURNOFF : 0;
    localparam int DRV_LIMIT    = PULSE_EFF - 1 - DRV_DELAY;
    localparam int MAXT         = int'(umax(umax(umax(T_SETUP, PULSE_EFF), umax(T_HOLD, T_ACCESS)),
                                            umax(T_TURNOFF, 1)));
    localparam int CW           = $clog2(MAXT + 1);

    seq_state_t state_q, state_d;

    logic          sem_q;
    logic [1:0]    be_q;
    logic [AW-1:0] addr_q;
    logic [15:0]   wdata_q;

    logic          accept;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic [CW-1:0] tmr_remain;
    logic          tmr_done;

    logic          en_on, lanes_on, rw_n, oe_n, dq_drv;
    logic [1:0]    lane_n;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Request capture: fields change only on acceptance, when all controls are high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sem_q   <= 1'b0;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            sem_q   <= req_sem;
            be_q    <= req_be;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)   state_d = req_write ? ST_SETUP : ST_READ;
            ST_SETUP: if (tmr_done) state_d = ST_PULSE;
            ST_PULSE: if (tmr_done) state_d = ST_HOLD;
            ST_HOLD:  if (tmr_done) state_d = ST_IDLE;
            ST_READ:  if (tmr_done) state_d = ST_TURN;
            ST_TURN:  if (tmr_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Interval selection on each state entry
    assign tmr_load = (state_d != state_q);

    always_comb begin
        tmr_val = CW'(1);
        unique case (state_d)
            ST_SETUP: tmr_val = CW'(T_SETUP);
            ST_PULSE: tmr_val = CW'(PULSE_EFF);
            ST_HOLD:  tmr_val = CW'(T_HOLD);
            ST_READ:  tmr_val = CW'(T_ACCESS);
            ST_TURN:  tmr_val = CW'(T_TURNOFF);
            default:  tmr_val = CW'(1);
        endcase
    end

    sram_seq_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .remain   (tmr_remain),
        .expired  (tmr_done)
    );

    // Outputs per state
    always_comb begin
        en_on    = 1'b0;
        lanes_on = 1'b0;
        rw_n     = 1'b1;
        oe_n     = 1'b1;
        dq_drv   = 1'b0;
        unique case (state_q)
            ST_SETUP: begin
                lanes_on = 1'b1;
                if (WMODE == 0) begin
                    en_on = 1'b1;
                    oe_n  = !OE_HELD;
                end else begin
                    rw_n   = 1'b0;
                    dq_drv = 1'b1;
                end
            end
            ST_PULSE: begin
                en_on    = 1'b1;
                lanes_on = 1'b1;
                rw_n     = 1'b0;
                if (WMODE == 0) begin
                    oe_n   = !OE_HELD;
                    dq_drv = (tmr_remain <= CW'(DRV_LIMIT));
                end else begin
                    dq_drv = 1'b1;
                end
            end
            ST_HOLD: begin
                lanes_on = 1'b1;
                dq_drv   = 1'b1;
                if (WMODE == 0) begin
                    en_on = 1'b1;
                end else begin
                    rw_n = 1'b0;
                end
            end
            ST_READ: begin
                en_on    = 1'b1;
                lanes_on = 1'b1;
                oe_n     = 1'b0;
            end
            default: ;
        endcase
    end

    sram_seq_strobes u_strb (
        .en_on    (en_on),
        .lanes_on (lanes_on),
        .sel_sem  (sem_q),
        .be       (be_q),
        .ce_n     (mem_ce_n),
        .sem_n    (mem_sem_n),
        .lane_n   (lane_n)
    );

    assign mem_ub_n = lane_n[1];
    assign mem_lb_n = lane_n[0];
    assign mem_rw_n = rw_n;
    assign mem_oe_n = oe_n;
    assign mem_addr = addr_q;
    assign mem_dq   = dq_drv ? wdata_q : 16'bz;

    // Read capture in the last access cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state_q == ST_READ) && tmr_done;
            if ((state_q == ST_READ) && tmr_done) begin
                rsp_rdata <= {be_q[1] ? mem_dq[15:8] : 8'h00,
                              be_q[0] ? mem_dq[7:0]  : 8'h00};
            end
        end
    end
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
    parameter int AW    = 12,
    parameter int WMODE = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_sem_n,
    input logic          mem_rw_n,
    input logic          mem_oe_n,
    input logic          mem_ub_n,
    input logic          mem_lb_n,
    input logic          dq_drv
);
    logic en_low, win;
    assign en_low = !(mem_ce_n && mem_sem_n);
    assign win    = en_low && !mem_rw_n && !(mem_ub_n && mem_lb_n);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_sem_n && mem_rw_n && mem_oe_n && mem_ub_n && mem_lb_n && !dq_drv));

    a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rw_n && en_low) |=> (mem_rw_n || !en_low || $stable(mem_addr)));

    a_r3_one_space: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_ce_n && !mem_sem_n));

    a_r5_enable_first: assert property (@(posedge clk) disable iff (!rst_n)
        (WMODE == 0 && $fell(mem_rw_n)) |-> $past(en_low));

    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (en_low && mem_rw_n && !mem_oe_n) |-> !dq_drv);

    a_r7_data_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win) |-> ($past(dq_drv) && dq_drv));

    a_r8_rw_first: assert property (@(posedge clk) disable iff (!rst_n)
        (WMODE == 1 && $rose(en_low) && !mem_rw_n) |-> $past(!mem_rw_n));

    a_r8_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        (WMODE == 1 && !mem_rw_n) |-> mem_oe_n);

    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_seq sram_seq_chk #(.AW(AW), .WMODE(WMODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_sem_n (mem_sem_n),
    .mem_rw_n  (mem_rw_n),
    .mem_oe_n  (mem_oe_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .dq_drv    (dq_drv)
);

// File: tb/sim_sram_model.sv
// Behavioural two-space memory with per-access phase measurement.
module sim_sram_model #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          sem_n,
    input  logic          rw_n,
    input  logic          oe_n,
    input  logic          ub_n,
    input  logic          lb_n,
    inout  wire  [15:0]   dq,
    output int            pub_cnt,
    output int            pub_pre,
    output int            pub_win,
    output int            pub_post
);
    logic [15:0] ram [32];
    logic [15:0] sem [32];
    logic [4:0]  ix;
    logic [15:0] word;
    logic        en_low, rd_on, busy, wwin;
    int          c_pre, c_win, c_post;

    assign ix     = addr[4:0];
    assign en_low = !ce_n || !sem_n;
    assign word   = !ce_n ? ram[ix] : sem[ix];
    assign rd_on  = en_low && rw_n && !oe_n && !(ub_n && lb_n);
    assign dq     = rd_on ? {ub_n ? 8'h00 : word[15:8], lb_n ? 8'h00 : word[7:0]} : 16'bz;
    assign busy   = en_low || !rw_n;
    assign wwin   = en_low && !rw_n;

    initial begin
        for (int i = 0; i < 32; i++) begin
            ram[i] = 16'h0;
            sem[i] = 16'h0;
        end
        pub_cnt = 0; pub_pre = 0; pub_win = 0; pub_post = 0;
        c_pre = 0; c_win = 0; c_post = 0;
    end

    always @(negedge clk) begin
        if (wwin) begin
            if (!ce_n) begin
                if (!ub_n) ram[ix][15:8] <= dq[15:8];
                if (!lb_n) ram[ix][7:0]  <= dq[7:0];
            end else begin
                if (!ub_n) sem[ix][15:8] <= dq[15:8];
                if (!lb_n) sem[ix][7:0]  <= dq[7:0];
            end
        end
        if (busy) begin
            if (wwin)            c_win  <= c_win + 1;
            else if (c_win == 0) c_pre  <= c_pre + 1;
            else                 c_post <= c_post + 1;
        end else if (c_pre != 0 || c_win != 0 || c_post != 0) begin
            pub_pre  <= c_pre;
            pub_win  <= c_win;
            pub_post <= c_post;
            pub_cnt  <= pub_cnt + 1;
            c_pre    <= 0;
            c_win    <= 0;
            c_post   <= 0;
        end
    end
endmodule

// File: tb/sim_sram_seq.sv
`timescale 1ns/1ps
module sim_sram_seq;
    localparam int AW  = 12;
    localparam int TS  = 2;
    localparam int TP  = 2;
    localparam int TDS = 2;
    localparam int TTO = 2;
    localparam int TH  = 1;
    localparam int TA  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          q_write, q_sem;
    logic [1:0]    q_be;
    logic [AW-1:0] q_addr;
    logic [15:0]   q_wdata;
    logic [1:0]    q_valid;

    logic          rdy [2];
    logic          rv  [2];
    logic [15:0]   rd  [2];
    logic [AW-1:0] ma  [2];
    logic          ce [2], sm [2], rw [2], oe [2], ub [2], lb [2];
    wire  [15:0]   dq0, dq1;
    int            pc [2], pp [2], pw [2], po [2];

    sram_seq #(.AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_DSETUP(TDS), .T_TURNOFF(TTO),
               .T_HOLD(TH), .T_ACCESS(TA), .WMODE(0), .OE_LOW_WR(1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(q_valid[0]), .req_ready(rdy[0]),
        .req_write(q_write), .req_sem(q_sem), .req_be(q_be), .req_addr(q_addr),
        .req_wdata(q_wdata), .rsp_valid(rv[0]), .rsp_rdata(rd[0]), .mem_addr(ma[0]),
        .mem_ce_n(ce[0]), .mem_sem_n(sm[0]), .mem_rw_n(rw[0]), .mem_oe_n(oe[0]),
        .mem_ub_n(ub[0]), .mem_lb_n(lb[0]), .mem_dq(dq0));

    sram_seq #(.AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_DSETUP(TDS), .T_TURNOFF(TTO),
               .T_HOLD(TH), .T_ACCESS(TA), .WMODE(1), .OE_LOW_WR(0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(q_valid[1]), .req_ready(rdy[1]),
        .req_write(q_write), .req_sem(q_sem), .req_be(q_be), .req_addr(q_addr),
        .req_wdata(q_wdata), .rsp_valid(rv[1]), .rsp_rdata(rd[1]), .mem_addr(ma[1]),
        .mem_ce_n(ce[1]), .mem_sem_n(sm[1]), .mem_rw_n(rw[1]), .mem_oe_n(oe[1]),
        .mem_ub_n(ub[1]), .mem_lb_n(lb[1]), .mem_dq(dq1));

    sim_sram_model #(.AW(AW)) m0 (.clk(clk), .addr(ma[0]), .ce_n(ce[0]), .sem_n(sm[0]),
        .rw_n(rw[0]), .oe_n(oe[0]), .ub_n(ub[0]), .lb_n(lb[0]), .dq(dq0),
        .pub_cnt(pc[0]), .pub_pre(pp[0]), .pub_win(pw[0]), .pub_post(po[0]));

    sim_sram_model #(.AW(AW)) m1 (.clk(clk), .addr(ma[1]), .ce_n(ce[1]), .sem_n(sm[1]),
        .rw_n(rw[1]), .oe_n(oe[1]), .ub_n(ub[1]), .lb_n(lb[1]), .dq(dq1),
        .pub_cnt(pc[1]), .pub_pre(pp[1]), .pub_win(pw[1]), .pub_post(po[1]));

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] exp_ram [2][32];
    logic [15:0] exp_sem [2][32];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_pulse(input int u);
        int a, b;
        a = (TP > TDS) ? TP : TDS;
        b = (TP > TTO + TDS) ? TP : TTO + TDS;
        return (u == 0) ? b : a;
    endfunction

    function automatic logic [15:0] exp_read(input int u, input bit s, input logic [1:0] be,
                                             input logic [4:0] a);
        logic [15:0] w;
        w = s ? exp_sem[u][a] : exp_ram[u][a];
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic do_op(input int u, input bit wr, input bit s, input logic [1:0] be,
                         input logic [4:0] a, input logic [15:0] d);
        int n;
        int base;
        logic [15:0] w;
        while (!rdy[u]) @(negedge clk);
        base = pc[u];
        q_write = wr; q_sem = s; q_be = be; q_addr = AW'(a); q_wdata = d;
        q_valid[u] = 1'b1;
        @(negedge clk);
        q_valid[u] = 1'b0;
        check(rdy[u] == 1'b0, "R1 ready low while busy", int'(rdy[u]), 0);
        if (wr) begin
            while (!rdy[u]) @(negedge clk);
            w = s ? exp_sem[u][a] : exp_ram[u][a];
            if (be[1]) w[15:8] = d[15:8];
            if (be[0]) w[7:0]  = d[7:0];
            if (s) exp_sem[u][a] = w; else exp_ram[u][a] = w;
        end else begin
            n = 1;
            while (!rv[u]) begin @(negedge clk); n++; end
            check(n == TA + 1, "R9 response after access time", n, TA + 1);
            check(rd[u] == exp_read(u, s, be, a), "R10 R4 read data", int'(rd[u]),
                  int'(exp_read(u, s, be, a)));
            n = 0;
            do begin @(negedge clk); n++; end while (!rdy[u]);
            check(n == TTO, "R9 turnaround", n, TTO);
        end
        @(negedge clk);
        @(negedge clk);
        check(pc[u] == base + 1, "R1 one bus cycle per request", pc[u] - base, 1);
        if (wr) begin
            check(pp[u] == TS, u == 0 ? "R5 setup" : "R8 setup", pp[u], TS);
            check(pw[u] == exp_pulse(u), u == 0 ? "R5 pulse" : "R8 pulse", pw[u], exp_pulse(u));
            check(po[u] == TH, "R7 hold", po[u], TH);
        end else begin
            check(pp[u] == TA && pw[u] == 0 && po[u] == 0, "R9 read phases", pp[u], TA);
        end
    endtask

    int cyc = 0;
    bit done = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        q_valid = 2'b00; q_write = 1'b0; q_sem = 1'b0; q_be = 2'b00;
        q_addr = '0; q_wdata = '0;
        for (int u = 0; u < 2; u++)
            for (int i = 0; i < 32; i++) begin
                exp_ram[u][i] = 16'h0;
                exp_sem[u][i] = 16'h0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            check(rdy[u] == 1'b1, "R1 reset ready", int'(rdy[u]), 1);
            check({ce[u], sm[u], rw[u], oe[u], ub[u], lb[u]} == 6'h3f, "R1 reset controls idle",
                  int'({ce[u], sm[u], rw[u], oe[u], ub[u], lb[u]}), 'h3f);
        end
        for (int u = 0; u < 2; u++) begin
            // R3: same address, both spaces, distinct data
            do_op(u, 1, 0, 2'b11, 5'd3, 16'hA55A);
            do_op(u, 1, 1, 2'b11, 5'd3, 16'h0001);
            do_op(u, 0, 0, 2'b11, 5'd3, 16'h0);
            do_op(u, 0, 1, 2'b11, 5'd3, 16'h0);
            // R4: all lanes off leaves content
            do_op(u, 1, 0, 2'b00, 5'd3, 16'hFFFF);
            do_op(u, 0, 0, 2'b11, 5'd3, 16'h0);
            // R4: single lanes
            do_op(u, 1, 0, 2'b10, 5'd7, 16'h1234);
            do_op(u, 1, 0, 2'b01, 5'd7, 16'hABCD);
            do_op(u, 0, 0, 2'b11, 5'd7, 16'h0);
            do_op(u, 0, 0, 2'b01, 5'd7, 16'h0);
            do_op(u, 0, 0, 2'b10, 5'd7, 16'h0);
            do_op(u, 0, 0, 2'b00, 5'd7, 16'h0);
            // Random mix
            for (int i = 0; i < 150; i++) begin
                do_op(u, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)),
                      16'($urandom));
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule